// File: doc/BRIEF.md
# Gang Strap and Suspend Pin Controller

This block owns one bidirectional board pin with two jobs. Immediately after reset the pin is left undriven, so the external pull resistor sets its level. The block reads that level once, through a two-flop synchronizer. A 1 on the pin selects ganged port power handling and a 0 selects per-port handling. Once a programmable delay has passed, the block turns the pin around and drives a global-suspend flag onto it. The polarity of that flag depends on the mode read from the pin.

The same mode result sets how the active-low over-current inputs and power-enable outputs of the downstream ports are wired up. In ganged mode a single pair, port 0, covers every port, and the other pairs are unused. In per-port mode each port has its own pair. A synchronized over-current condition removes power from the affected port or ports. It also sets sticky status bits, and a clear strobe resets them. All delays are counted in ticks of an internal prescaler, so simulation can use short values.

Top module: `strap_suspend_ctrl`

## Requirements
- R1: `pad_oe` is 0 from reset until DIV*SWITCH_TICKS clock edges after reset release. From that edge on it is 1 and stays 1 until the next reset.
- R2: The pin level passes through two flops and is captured once, on clock edge DIV*SAMPLE_TICKS+1 after reset release. Any later change on `pad_in` has no effect on `gang_mode` until the next reset.
- R3: In ganged mode (`gang_mode`=1) with `pad_oe`=1, `pad_out` equals `suspend_req`. It is 0 in normal operation and 1 in suspend.
- R4: In per-port mode (`gang_mode`=0) with `pad_oe`=1, `pad_out` is the inverse of `suspend_req`. It is 1 in normal operation and 0 in suspend.
- R5: While `pad_oe`=0, `pad_out` holds the normal-operation level of the current mode, which is the inverse of `gang_mode`. As a result the pin does not glitch when the output enable turns on.
- R6: Until the mode has been captured, every bit of `pwr_en_n` is 1 (off), and no status bit is set.
- R7: In per-port mode, `pwr_en_n[i]` is 0 only when `port_pwr_req[i]`=1 and the synchronized `oc_n[i]`=1. The output is registered, so a change in `oc_n` shows up 3 clock edges later and a change in the request 1 edge later.
- R8: In ganged mode, `pwr_en_n[0]` is 0 only when any `port_pwr_req` bit is 1 and the synchronized `oc_n[0]`=1. All other `pwr_en_n` bits stay 1, and `oc_n` bits above 0 are ignored.
- R9: `oc_status[i]` is sticky. It is set by a synchronized low on `oc_n[i]` in per-port mode. In ganged mode a low on `oc_n[0]` sets every bit. `oc_clr`=1 clears the bits, and a set in the same cycle wins over the clear.
- R10: `gang_mode` is 0 out of reset and shows the captured pin level from the capture edge onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 1 | Level read back from the pin |
| pad_out | output | 1 | Value driven onto the pin when enabled |
| pad_oe | output | 1 | Pin output enable |
| suspend_req | input | 1 | Global suspend is in effect |
| port_pwr_req | input | NPORTS | Per-port power-on request from the hub logic |
| oc_n | input | NPORTS | Active-low over-current inputs |
| pwr_en_n | output | NPORTS | Active-low power-enable outputs |
| oc_clr | input | 1 | Clears the sticky over-current status |
| oc_status | output | NPORTS | Sticky over-current status |
| gang_mode | output | 1 | Captured mode, 1 = ganged |

## Verification
The assertions assume that `pad_in` is steady for at least two clock edges before the capture edge. If it is not, the synchronizer may capture either value. The bench therefore sets the strap level while reset is held and changes it only well after capture, to show that late changes are ignored. The assertions also assume that `oc_n`, `port_pwr_req`, `suspend_req` and `oc_clr` are synchronous to `clk` or are allowed to be sampled late. The bench changes all of them on the falling edge with random values. This covers both modes and lets over-current pulses coincide with clear strobes.

// File: rtl/sss_pkg.sv
package sss_pkg;
  // Pin level for a given mode and suspend state
  function automatic logic pad_level(input logic gang, input logic susp);
    return gang ? susp : ~susp;
  endfunction

  // Power enable (active low) for one port: request and no over-current
  function automatic logic pwr_off(input logic req, input logic oc_ok);
    return ~(req & oc_ok);
  endfunction
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end
  assign q = s2_q;
endmodule

// File: rtl/sss_timer.sv
module sss_timer #(
  parameter int DIV          = 1000,
  parameter int SAMPLE_TICKS = 20,
  parameter int SWITCH_TICKS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic sample_evt,
  output logic out_phase
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CNT_W = $clog2(SWITCH_TICKS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [CNT_W-1:0] SMP_C    = CNT_W'(SAMPLE_TICKS);
  localparam logic [CNT_W-1:0] SW_C     = CNT_W'(SWITCH_TICKS);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick && cnt_q != SW_C) cnt_q <= cnt_q + 1'b1;
      if (sample_evt) done_q <= 1'b1;
    end
  end

  assign sample_evt = (cnt_q == SMP_C) && !done_q;
  assign out_phase  = (cnt_q == SW_C);
endmodule

// File: rtl/sss_pwrmap.sv
module sss_pwrmap #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              gang,
  input  logic [NPORTS-1:0] req,
  input  logic [NPORTS-1:0] oc_ok,
  input  logic              clr,
  output logic [NPORTS-1:0] pwr_en_n,
  output logic [NPORTS-1:0] status
);
  import sss_pkg::*;

  logic [NPORTS-1:0] pwr_d, set_d;
  logic              any_req;

  assign any_req = |req;

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    if (i == 0) begin : g_lead
      assign pwr_d[i] = gang ? pwr_off(any_req, oc_ok[0]) : pwr_off(req[i], oc_ok[i]);
      assign set_d[i] = ~oc_ok[0];
    end else begin : g_rest
      assign pwr_d[i] = gang ? 1'b1 : pwr_off(req[i], oc_ok[i]);
      assign set_d[i] = gang ? ~oc_ok[0] : ~oc_ok[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_en_n <= '1;
      status   <= '0;
    end else begin
      pwr_en_n <= active ? pwr_d : '1;
      status   <= (clr ? '0 : status) | (active ? set_d : '0);
    end
  end
endmodule

// File: rtl/strap_suspend_ctrl.sv
module strap_suspend_ctrl #(
  parameter int NPORTS       = 4,
  parameter int DIV          = 1000,
  parameter int SAMPLE_TICKS = 20,
  parameter int SWITCH_TICKS = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  input  logic              suspend_req,
  input  logic [NPORTS-1:0] port_pwr_req,
  input  logic [NPORTS-1:0] oc_n,
  output logic [NPORTS-1:0] pwr_en_n,
  input  logic              oc_clr,
  output logic [NPORTS-1:0] oc_status,
  output logic              gang_mode
);
  import sss_pkg::*;

  // Named internal events, visible to the checker
  logic              sample_evt;
  logic              out_phase;
  logic              strap_sync;
  logic              strap_latched;
  logic [NPORTS-1:0] oc_ok;

  sss_timer #(
    .DIV(DIV), .SAMPLE_TICKS(SAMPLE_TICKS), .SWITCH_TICKS(SWITCH_TICKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .out_phase(out_phase)
  );

  sss_sync #(.W(1), .RST_VAL(1'b0)) u_strap_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(strap_sync)
  );

  sss_sync #(.W(NPORTS), .RST_VAL({NPORTS{1'b1}})) u_oc_sync (
    .clk(clk), .rst_n(rst_n), .d(oc_n), .q(oc_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gang_mode     <= 1'b0;
      strap_latched <= 1'b0;
    end else if (sample_evt) begin
      gang_mode     <= strap_sync;
      strap_latched <= 1'b1;
    end
  end

  assign pad_oe  = out_phase;
  assign pad_out = pad_level(gang_mode, out_phase & suspend_req);

  sss_pwrmap #(.NPORTS(NPORTS)) u_pwr (
    .clk(clk), .rst_n(rst_n), .active(strap_latched), .gang(gang_mode),
    .req(port_pwr_req), .oc_ok(oc_ok), .clr(oc_clr),
    .pwr_en_n(pwr_en_n), .status(oc_status)
  );
endmodule

// File: rtl/strap_suspend_ctrl_chk.sv
module strap_suspend_ctrl_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pad_out,
  input logic              pad_oe,
  input logic              suspend_req,
  input logic [NPORTS-1:0] pwr_en_n,
  input logic              oc_clr,
  input logic [NPORTS-1:0] oc_status,
  input logic              gang_mode,
  input logic              strap_latched,
  input logic [NPORTS-1:0] oc_ok
);
  p_oe_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |=> pad_oe);

  p_strap_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strap_latched |=> (strap_latched && $stable(gang_mode)));

  p_gang_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && gang_mode) |-> (pad_out == suspend_req));

  p_indiv_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && !gang_mode) |-> (pad_out != suspend_req));

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> (pad_out == !gang_mode));

  p_off_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_latched |=> (&pwr_en_n));

  p_oc_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_latched && !gang_mode) |=> ((~$past(oc_ok) & ~pwr_en_n) == '0));

  p_gang_spare_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_latched && gang_mode) |=> (&pwr_en_n[NPORTS-1:1]));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_clr |=> ((oc_status & $past(oc_status)) == $past(oc_status)));
endmodule

bind strap_suspend_ctrl strap_suspend_ctrl_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pad_out(pad_out), .pad_oe(pad_oe),
  .suspend_req(suspend_req), .pwr_en_n(pwr_en_n), .oc_clr(oc_clr),
  .oc_status(oc_status), .gang_mode(gang_mode),
  .strap_latched(strap_latched), .oc_ok(oc_ok)
);

// File: tb/tb_strap_suspend_ctrl.sv
module tb_strap_suspend_ctrl;
  localparam int N  = 4;
  localparam int DV = 4;
  localparam int SM = 3;
  localparam int SW = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pad_in = 1'b0;
  logic         suspend_req = 1'b0;
  logic [N-1:0] port_pwr_req = '0;
  logic [N-1:0] oc_n = '1;
  logic         oc_clr = 1'b0;
  logic         pad_out, pad_oe, gang_mode;
  logic [N-1:0] pwr_en_n, oc_status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  strap_suspend_ctrl #(.NPORTS(N), .DIV(DV), .SAMPLE_TICKS(SM), .SWITCH_TICKS(SW)) dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .suspend_req(suspend_req), .port_pwr_req(port_pwr_req), .oc_n(oc_n),
    .pwr_en_n(pwr_en_n), .oc_clr(oc_clr), .oc_status(oc_status), .gang_mode(gang_mode)
  );

  // Behavioural reference: edge counting plus delayed copies of inputs
  int           edges;
  bit           m_latched, m_gang, m_oe;
  bit           m_st1, m_st2;
  bit [N-1:0]   m_oc1, m_oc2, m_pwr, m_stat;

  always @(posedge clk) begin
    if (!rst_n) begin
      edges = 0; m_latched = 0; m_gang = 0; m_oe = 0;
      m_st1 = 0; m_st2 = 0; m_oc1 = '1; m_oc2 = '1;
      m_pwr = '1; m_stat = '0;
    end else begin
      bit [N-1:0] np, ns;
      np = '1;
      ns = oc_clr ? '0 : m_stat;
      if (m_latched) begin
        if (m_gang) begin
          np[0] = !((port_pwr_req != 0) && m_oc2[0]);
          if (!m_oc2[0]) ns = '1;
        end else begin
          for (int i = 0; i < N; i++) begin
            np[i] = !(port_pwr_req[i] && m_oc2[i]);
            if (!m_oc2[i]) ns[i] = 1'b1;
          end
        end
      end
      m_pwr = np;
      m_stat = ns;
      if (!m_latched && (edges / DV) == SM) begin
        m_latched = 1; m_gang = m_st2;
      end
      edges++;
      m_oe = (edges >= DV * SW);
      m_st2 = m_st1; m_st1 = pad_in;
      m_oc2 = m_oc1; m_oc1 = oc_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at edge %0d", req, act, exp, edges);
    end
  endtask

  task automatic compare_all();
    bit exp_out;
    check(pad_oe == m_oe, "R1 pad_oe", pad_oe, m_oe);
    check(gang_mode == m_gang, (edges > DV*SM + 1) ? "R2 mode held" : "R10 mode", gang_mode, m_gang);
    exp_out = m_oe ? (m_gang ? suspend_req : !suspend_req) : !m_gang;
    check(pad_out == exp_out, !m_oe ? "R5 idle level" : (m_gang ? "R3 gang level" : "R4 indiv level"),
          pad_out, exp_out);
    check(pwr_en_n == m_pwr, !m_latched ? "R6 power off" : (m_gang ? "R8 gang power" : "R7 port power"),
          pwr_en_n, m_pwr);
    check(oc_status == m_stat, "R9 status", oc_status, m_stat);
  endtask

  task automatic run_phase(input bit strap, input int cycles);
    rst_n = 1'b0;
    pad_in = strap;
    repeat (3) @(negedge clk);
    // reset state checks
    check(pad_oe == 1'b0, "R1 reset oe", pad_oe, 0);
    check(pwr_en_n == '1, "R6 reset power", pwr_en_n, 4'hf);
    check(pad_out == 1'b1, "R5 reset level", pad_out, 1);
    rst_n = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all();
      if (c == 80) pad_in = !strap;   // late change must be ignored (R2)
      suspend_req  = ($urandom % 4) == 0;
      port_pwr_req = N'($urandom);
      oc_n         = ~(N'($urandom) & N'($urandom) & N'($urandom));
      oc_clr       = ($urandom % 8) == 0;
    end
  endtask

  initial begin
    run_phase(1'b1, 400);
    run_phase(1'b0, 400);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule